// File: doc/BRIEF.md
# Oversampling Asynchronous Serial Receiver

This block turns an NRZ serial line into parallel characters, least significant bit first. A sample-rate enable arrives sixteen times per bit period. The receiver synchronises the line and rejects short low glitches by re-checking the start bit at its centre. It samples each following bit sixteen ticks after the one before. It checks parity and the stop bit, and it drops the parity bit before the character reaches the data register.

A finished character moves into a single holding register, and a full flag rises. Parity, framing and overrun flags describe that character. The host takes the character by pulsing a read strobe, which empties the register and clears all three error flags. If the register is still full when a new character finishes, the new character is discarded and the overrun flag marks the loss. After a break, meaning an all-zero character with a low stop bit, the receiver stays idle until it has seen the line at mark level.

Word length, parity enable, parity mode and the stop-bit selection are static configuration inputs. They are held steady while a character is on the line.

Top module: `rxo_receiver`

## Requirements
- R1: After reset, `rx_full`, `err_overrun`, `err_frame` and `err_parity` are 0 and `rx_data` is all zeros.
- R2: A low level that is high again at the centre sample of the start bit (eight ticks after the low was first seen) does not start a character. No character is produced, and the next real character is received intact.
- R3: `cfg_wlen` codes 0, 1, 2 and 3 select 5, 6, 7 and 8 data bits. The first data bit on the line lands in `rx_data[0]`. Unused high bits read as 0, and the parity bit never appears in `rx_data`.
- R4: With normal stop timing, `rx_full` is set on the 16x tick that follows the centre sample of the first stop bit, which is 9/16 of the way into that stop bit.
- R5: When `cfg_stop_sel` is 1, the word is 5 bits and parity is disabled (one and a half stop bits), `rx_full` is set 12 ticks after the stop-bit centre sample. That point is halfway through the trailing half stop bit. With any other word length or with parity, `cfg_stop_sel` leaves the R4 timing unchanged.
- R6: If a character finishes while `rx_full` is 1 and no read is strobed, `err_overrun` sets. `rx_full` stays 1 and `rx_data` keeps the earlier character.
- R7: A low stop bit sets `err_frame` together with `rx_full`. Reception continues, and each later character sets or clears the flag by its own stop bit.
- R8: `cfg_par_mode` 0 (odd) flags an error when the count of ones in data plus parity bit is even. Mode 1 (even) flags an error when that count is odd. Modes 2 (mark) and 3 (space), or `cfg_par_en` = 0, never set `err_parity`.
- R9: A one-cycle `rd_strobe` clears `rx_full`, `err_overrun`, `err_frame` and `err_parity` on the next clock edge and leaves `rx_data` unchanged.
- R10: A break character is reported once, with `err_frame` set. While the line stays low afterwards, no further character is produced. Reception resumes after the line has been seen high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick16 | input | 1 | Sample enable, 16 pulses per bit period |
| rxd | input | 1 | Serial input line, idle high |
| cfg_wlen | input | 2 | Word length code: 5 + code data bits |
| cfg_par_en | input | 1 | Parity bit present when 1 |
| cfg_par_mode | input | 2 | 0 odd, 1 even, 2 mark, 3 space |
| cfg_stop_sel | input | 1 | Extended stop selection (1.5 stop bits for 5-bit words without parity) |
| rd_strobe | input | 1 | Host read of the data register |
| rx_data | output | DATA_W | Received character, zero-extended |
| rx_full | output | 1 | Data register holds an unread character |
| err_overrun | output | 1 | A character was lost while the register was full |
| err_frame | output | 1 | Stop bit of the held character was low |
| err_parity | output | 1 | Parity of the held character was wrong |

## Verification
Four rules are checked on every cycle against the internal character-complete strobe:
- an empty register loads exactly the finished character;
- an overrun leaves the held data untouched;
- a read clears the full flag and every error flag;
- an error flag is never set while the register is empty.

The same checks confirm that completion happens only on a sample tick and that unchecked parity modes never raise a parity error. Other behaviour can only be shown by driving whole frames in the bench:
- the exact tick at which the full flag rises for normal and one-and-a-half stop bits;
- rejection of a glitch that is gone by the start-bit centre;
- data masking for each word length;
- silence during a held break.

// File: rtl/rxo_pkg.sv
package rxo_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP,
        ST_HOLD,
        ST_WAIT_MARK
    } rx_state_e;

    typedef enum logic [1:0] {
        PAR_ODD   = 2'd0,
        PAR_EVEN  = 2'd1,
        PAR_MARK  = 2'd2,
        PAR_SPACE = 2'd3
    } par_mode_e;

endpackage

// File: rtl/rxo_sync.sv
module rxo_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '1;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], din};
        end
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/rxo_frame.sv
module rxo_frame
    import rxo_pkg::*;
#(
    parameter int OVS    = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              rx,
    input  logic [1:0]        wlen,
    input  logic              par_en,
    input  logic [1:0]        par_mode,
    input  logic              stop_sel,
    output logic              done,
    output logic [DATA_W-1:0] data,
    output logic              perr,
    output logic              ferr
);
    localparam int CNT_W     = $clog2(OVS);
    localparam int IDX_W     = $clog2(DATA_W);
    localparam int MID       = OVS / 2 - 1;
    localparam int LAST      = OVS - 1;
    localparam int HOLD_LONG = OVS / 2 + OVS / 4;

    typedef struct packed {
        rx_state_e          state;
        logic [CNT_W-1:0]   cnt;
        logic [IDX_W-1:0]   idx;
        logic [DATA_W-1:0]  data;
        logic               pbit;
        logic               sbit;
        logic               seen1;
    } frame_t;

    frame_t fr_d, fr_q;

    logic [IDX_W-1:0] last_idx;
    logic [CNT_W-1:0] hold_last;
    logic             long_stop;
    logic             xor_all;

    always_comb begin
        fr_d      = fr_q;
        done      = 1'b0;
        last_idx  = IDX_W'(DATA_W - 4) + IDX_W'(wlen);
        long_stop = stop_sel && (wlen == 2'd0) && !par_en;
        hold_last = long_stop ? CNT_W'(HOLD_LONG - 1) : '0;

        if (tick) begin
            unique case (fr_q.state)
                ST_IDLE: begin
                    if (!rx) begin
                        fr_d.state = ST_START;
                        fr_d.cnt   = '0;
                    end
                end
                ST_START: begin
                    if (fr_q.cnt == CNT_W'(MID)) begin
                        if (rx) begin
                            fr_d.state = ST_IDLE;
                        end else begin
                            fr_d.state = ST_DATA;
                            fr_d.cnt   = '0;
                            fr_d.idx   = '0;
                            fr_d.data  = '0;
                            fr_d.pbit  = 1'b0;
                            fr_d.seen1 = 1'b0;
                        end
                    end else begin
                        fr_d.cnt = fr_q.cnt + 1'b1;
                    end
                end
                ST_DATA: begin
                    if (fr_q.cnt == CNT_W'(LAST)) begin
                        fr_d.cnt            = '0;
                        fr_d.data[fr_q.idx] = rx;
                        fr_d.seen1          = fr_q.seen1 | rx;
                        if (fr_q.idx == last_idx) begin
                            fr_d.state = par_en ? ST_PAR : ST_STOP;
                        end else begin
                            fr_d.idx = fr_q.idx + 1'b1;
                        end
                    end else begin
                        fr_d.cnt = fr_q.cnt + 1'b1;
                    end
                end
                ST_PAR: begin
                    if (fr_q.cnt == CNT_W'(LAST)) begin
                        fr_d.cnt   = '0;
                        fr_d.pbit  = rx;
                        fr_d.seen1 = fr_q.seen1 | rx;
                        fr_d.state = ST_STOP;
                    end else begin
                        fr_d.cnt = fr_q.cnt + 1'b1;
                    end
                end
                ST_STOP: begin
                    if (fr_q.cnt == CNT_W'(LAST)) begin
                        fr_d.cnt   = '0;
                        fr_d.sbit  = rx;
                        fr_d.state = ST_HOLD;
                    end else begin
                        fr_d.cnt = fr_q.cnt + 1'b1;
                    end
                end
                ST_HOLD: begin
                    if (fr_q.cnt == hold_last) begin
                        done       = 1'b1;
                        fr_d.cnt   = '0;
                        fr_d.state = (!fr_q.sbit && !fr_q.seen1) ? ST_WAIT_MARK : ST_IDLE;
                    end else begin
                        fr_d.cnt = fr_q.cnt + 1'b1;
                    end
                end
                ST_WAIT_MARK: begin
                    if (rx) begin
                        fr_d.state = ST_IDLE;
                    end
                end
                default: fr_d.state = ST_IDLE;
            endcase
        end

        xor_all = (^fr_q.data) ^ fr_q.pbit;
        data    = fr_q.data;
        ferr    = !fr_q.sbit;
        perr    = par_en && !par_mode[1] && (xor_all == par_mode[0]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fr_q       <= '0;
            fr_q.state <= ST_IDLE;
            fr_q.sbit  <= 1'b1;
        end else begin
            fr_q <= fr_d;
        end
    end
endmodule

// File: rtl/rxo_holdreg.sv
module rxo_holdreg #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    input  logic              load_perr,
    input  logic              load_ferr,
    input  logic              rd,
    output logic [DATA_W-1:0] data,
    output logic              full,
    output logic              ovr,
    output logic              fe,
    output logic              pe
);
    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              full;
        logic              ovr;
        logic              fe;
        logic              pe;
    } hold_t;

    hold_t hr_d, hr_q;

    always_comb begin
        hr_d = hr_q;
        if (load) begin
            if (hr_q.full && !rd) begin
                hr_d.ovr = 1'b1;
            end else begin
                hr_d.data = load_data;
                hr_d.full = 1'b1;
                hr_d.fe   = load_ferr;
                hr_d.pe   = load_perr;
                hr_d.ovr  = 1'b0;
            end
        end else if (rd) begin
            hr_d.full = 1'b0;
            hr_d.ovr  = 1'b0;
            hr_d.fe   = 1'b0;
            hr_d.pe   = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hr_q <= '0;
        end else begin
            hr_q <= hr_d;
        end
    end

    assign data = hr_q.data;
    assign full = hr_q.full;
    assign ovr  = hr_q.ovr;
    assign fe   = hr_q.fe;
    assign pe   = hr_q.pe;
endmodule

// File: rtl/rxo_receiver.sv
module rxo_receiver #(
    parameter int OVS         = 16,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick16,
    input  logic              rxd,
    input  logic [1:0]        cfg_wlen,
    input  logic              cfg_par_en,
    input  logic [1:0]        cfg_par_mode,
    input  logic              cfg_stop_sel,
    input  logic              rd_strobe,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_full,
    output logic              err_overrun,
    output logic              err_frame,
    output logic              err_parity
);
    logic              rx_s;
    logic              char_done;
    logic [DATA_W-1:0] char_data;
    logic              char_perr;
    logic              char_ferr;

    rxo_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (rxd),
        .dout (rx_s)
    );

    rxo_frame #(.OVS(OVS), .DATA_W(DATA_W)) u_frame (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick16),
        .rx      (rx_s),
        .wlen    (cfg_wlen),
        .par_en  (cfg_par_en),
        .par_mode(cfg_par_mode),
        .stop_sel(cfg_stop_sel),
        .done    (char_done),
        .data    (char_data),
        .perr    (char_perr),
        .ferr    (char_ferr)
    );

    rxo_holdreg #(.DATA_W(DATA_W)) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (char_done),
        .load_data(char_data),
        .load_perr(char_perr),
        .load_ferr(char_ferr),
        .rd       (rd_strobe),
        .data     (rx_data),
        .full     (rx_full),
        .ovr      (err_overrun),
        .fe       (err_frame),
        .pe       (err_parity)
    );
endmodule

// File: rtl/rxo_receiver_chk.sv
module rxo_receiver_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick16,
    input logic              cfg_par_en,
    input logic [1:0]        cfg_par_mode,
    input logic              rd_strobe,
    input logic              char_done,
    input logic [DATA_W-1:0] char_data,
    input logic [DATA_W-1:0] rx_data,
    input logic              rx_full,
    input logic              err_overrun,
    input logic              err_frame,
    input logic              err_parity
);
    AST_DONE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        char_done |-> tick16); // R4

    AST_LOAD_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        char_done && !rx_full |=> rx_full && (rx_data == $past(char_data))); // R3

    AST_OVERRUN_KEEPS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        char_done && rx_full && !rd_strobe |=> rx_full && err_overrun && $stable(rx_data)); // R6

    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        rd_strobe && !char_done |=> !rx_full && !err_overrun && !err_frame && !err_parity
                                    && $stable(rx_data)); // R9

    AST_NO_PARITY_UNCHECKED: assert property (@(posedge clk) disable iff (!rst_n)
        char_done && !rx_full && (!cfg_par_en || cfg_par_mode[1]) |=> !err_parity); // R8

    AST_FLAGS_NEED_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (err_overrun || err_frame || err_parity) |-> rx_full); // R7
endmodule

bind rxo_receiver rxo_receiver_chk #(.DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick16      (tick16),
    .cfg_par_en  (cfg_par_en),
    .cfg_par_mode(cfg_par_mode),
    .rd_strobe   (rd_strobe),
    .char_done   (char_done),
    .char_data   (char_data),
    .rx_data     (rx_data),
    .rx_full     (rx_full),
    .err_overrun (err_overrun),
    .err_frame   (err_frame),
    .err_parity  (err_parity)
);

// File: tb/rxo_receiver_test.sv
module rxo_receiver_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick16 = 1'b0;
    logic       rxd = 1'b1;
    logic [1:0] cfg_wlen = 2'd3;
    logic       cfg_par_en = 1'b0;
    logic [1:0] cfg_par_mode = 2'd0;
    logic       cfg_stop_sel = 1'b0;
    logic       mon_rd = 1'b0;
    logic       man_rd = 1'b0;
    logic       rd_strobe;
    logic [7:0] rx_data;
    logic       rx_full, err_overrun, err_frame, err_parity;
    logic [1:0] tdiv = 2'd0;

    typedef struct {
        logic [7:0] data;
        logic       pe;
        logic       fe;
    } exp_t;

    exp_t exp_q[$];
    int   checks = 0;
    int   fails = 0;
    int   rx_count = 0;
    bit   auto_rd = 1'b1;

    assign rd_strobe = mon_rd | man_rd;

    always #4 clk = ~clk;

    always @(negedge clk) begin
        tdiv   = tdiv + 2'd1;
        tick16 = (tdiv == 2'd0);
    end

    rxo_receiver uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick16      (tick16),
        .rxd         (rxd),
        .cfg_wlen    (cfg_wlen),
        .cfg_par_en  (cfg_par_en),
        .cfg_par_mode(cfg_par_mode),
        .cfg_stop_sel(cfg_stop_sel),
        .rd_strobe   (rd_strobe),
        .rx_data     (rx_data),
        .rx_full     (rx_full),
        .err_overrun (err_overrun),
        .err_frame   (err_frame),
        .err_parity  (err_parity)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    task automatic wait_ticks(input int n);
        repeat (n) begin
            @(posedge clk);
            while (!tick16) @(posedge clk);
        end
        @(negedge clk);
    endtask

    function automatic logic [7:0] wmask();
        return 8'hFF >> (2'd3 - cfg_wlen);
    endfunction

    function automatic logic [11:0] mk_frame(input logic [7:0] d, input bit bad_par,
                                             input bit stop_lvl, output int n);
        logic [11:0] bits;
        logic [7:0]  dm;
        logic        p;
        int          pos;
        int          nb;
        bits = '1;
        dm   = d & wmask();
        nb   = 5 + int'(cfg_wlen);
        bits[0] = 1'b0;
        for (int i = 0; i < nb; i++) bits[1 + i] = d[i];
        pos = 1 + nb;
        if (cfg_par_en) begin
            case (cfg_par_mode)
                2'd0:    p = ~^dm;
                2'd1:    p = ^dm;
                2'd2:    p = 1'b1;
                default: p = 1'b0;
            endcase
            bits[pos] = p ^ bad_par;
            pos++;
        end
        bits[pos] = stop_lvl;
        n = pos + 1;
        return bits;
    endfunction

    task automatic send_frame(input logic [11:0] bits, input int n);
        for (int i = 0; i < n; i++) begin
            rxd = bits[i];
            wait_ticks(16);
        end
        rxd = 1'b1;
    endtask

    // Driver: pushes the expected item, then drives the frame and an idle gap.
    task automatic send_char(input logic [7:0] d, input bit bad_par, input bit stop_lvl);
        logic [11:0] bits;
        int          n;
        exp_t        e;
        bits   = mk_frame(d, bad_par, stop_lvl, n);
        e.data = d & wmask();
        e.pe   = bad_par && cfg_par_en && !cfg_par_mode[1];
        e.fe   = !stop_lvl;
        exp_q.push_back(e);
        send_frame(bits, n);
        wait_ticks(8);
    endtask

    // Monitor: pops and compares each character as it becomes available.
    always @(negedge clk) begin
        if (mon_rd) begin
            mon_rd = 1'b0;
        end else if (rst_n && auto_rd && rx_full) begin
            rx_count++;
            if (exp_q.size() == 0) begin
                chk("R10 unexpected character", 32'd1, 32'd0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk("R3 data", {24'd0, rx_data}, {24'd0, e.data});
                chk("R8 parity flag", {31'd0, err_parity}, {31'd0, e.pe});
                chk("R7 framing flag", {31'd0, err_frame}, {31'd0, e.fe});
                chk("R6 no overrun", {31'd0, err_overrun}, 32'd0);
            end
            mon_rd = 1'b1;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        summary();
    end

    initial begin
        logic [11:0] fbits;
        int          fn;
        int          cnt0;

        repeat (5) @(negedge clk);
        chk("R1 full after reset", {31'd0, rx_full}, 32'd0);
        chk("R1 flags after reset", {29'd0, err_overrun, err_frame, err_parity}, 32'd0);
        chk("R1 data after reset", {24'd0, rx_data}, 32'd0);
        rst_n = 1'b1;
        wait_ticks(4);
        chk("R1 idle after reset", {31'd0, rx_full}, 32'd0);

        // R3: eight-bit words, no parity
        send_char(8'hA5, 1'b0, 1'b1);
        send_char(8'h3C, 1'b0, 1'b1);
        // R3: shorter words mask the upper bits
        for (int wl = 0; wl < 3; wl++) begin
            cfg_wlen = 2'(wl);
            send_char(8'hFF, 1'b0, 1'b1);
            send_char(8'hB6, 1'b0, 1'b1);
        end
        cfg_wlen = 2'd3;

        // R8: parity modes
        cfg_par_en = 1'b1;
        for (int m = 0; m < 4; m++) begin
            cfg_par_mode = 2'(m);
            send_char(8'h5A, 1'b0, 1'b1);
            send_char(8'h5B, 1'b1, 1'b1);
        end
        cfg_par_mode = 2'd1;

        // R4: full at 9/16 of the stop bit (stop is bit 10 here)
        fbits = mk_frame(8'h81, 1'b0, 1'b1, fn);
        fork
            send_char(8'h81, 1'b0, 1'b1);
            begin
                wait_ticks(16 * 10 + 9);
                chk("R4 full not before stop report", {31'd0, rx_full}, 32'd0);
                wait_ticks(1);
                chk("R4 full at stop 9/16", {31'd0, rx_full}, 32'd1);
            end
        join

        // R5: one and a half stop bits, 5-bit word, no parity (stop is bit 6)
        cfg_par_en   = 1'b0;
        cfg_wlen     = 2'd0;
        cfg_stop_sel = 1'b1;
        fork
            send_char(8'h15, 1'b0, 1'b1);
            begin
                wait_ticks(16 * 6 + 20);
                chk("R5 full not before trailing half", {31'd0, rx_full}, 32'd0);
                wait_ticks(1);
                chk("R5 full mid trailing half", {31'd0, rx_full}, 32'd1);
            end
        join
        wait_ticks(8);
        // R5: stop select with 8-bit words keeps normal timing (stop is bit 9)
        cfg_wlen = 2'd3;
        fork
            send_char(8'h42, 1'b0, 1'b1);
            begin
                wait_ticks(16 * 9 + 10);
                chk("R5 two-stop keeps 9/16 report", {31'd0, rx_full}, 32'd1);
            end
        join
        cfg_stop_sel = 1'b0;

        // R7: framing error, then a clean character clears it
        send_char(8'h6E, 1'b0, 1'b0);
        send_char(8'h11, 1'b0, 1'b1);

        // R2: short glitch is not a start bit
        cnt0 = rx_count;
        rxd  = 1'b0;
        wait_ticks(4);
        rxd  = 1'b1;
        wait_ticks(40);
        chk("R2 glitch gives no character", {31'd0, rx_full}, 32'd0);
        chk("R2 glitch count", rx_count, cnt0);
        send_char(8'hC3, 1'b0, 1'b1);

        // R6 and R9: overrun keeps the older character; read clears flags
        wait_ticks(40);
        auto_rd = 1'b0;
        fbits = mk_frame(8'h9D, 1'b0, 1'b1, fn);
        send_frame(fbits, fn);
        wait_ticks(8);
        chk("R6 first char held", {24'd0, rx_data}, 32'h9D);
        chk("R6 no overrun yet", {31'd0, err_overrun}, 32'd0);
        fbits = mk_frame(8'h24, 1'b0, 1'b1, fn);
        send_frame(fbits, fn);
        wait_ticks(8);
        chk("R6 overrun set", {31'd0, err_overrun}, 32'd1);
        chk("R6 full kept", {31'd0, rx_full}, 32'd1);
        chk("R6 old data kept", {24'd0, rx_data}, 32'h9D);
        man_rd = 1'b1;
        @(negedge clk);
        man_rd = 1'b0;
        chk("R9 read clears full", {31'd0, rx_full}, 32'd0);
        chk("R9 read clears overrun", {31'd0, err_overrun}, 32'd0);
        chk("R9 data kept after read", {24'd0, rx_data}, 32'h9D);
        wait_ticks(2);
        fbits = mk_frame(8'h77, 1'b0, 1'b0, fn);
        send_frame(fbits, fn);
        wait_ticks(8);
        chk("R7 frame flag held", {31'd0, err_frame}, 32'd1);
        man_rd = 1'b1;
        @(negedge clk);
        man_rd = 1'b0;
        chk("R9 read clears frame flag", {31'd0, err_frame}, 32'd0);
        cfg_par_en   = 1'b1;
        cfg_par_mode = 2'd0;
        wait_ticks(2);
        fbits = mk_frame(8'h01, 1'b1, 1'b1, fn);
        send_frame(fbits, fn);
        wait_ticks(8);
        chk("R8 odd parity error held", {31'd0, err_parity}, 32'd1);
        man_rd = 1'b1;
        @(negedge clk);
        man_rd = 1'b0;
        chk("R9 read clears parity flag", {31'd0, err_parity}, 32'd0);
        cfg_par_en = 1'b0;
        auto_rd    = 1'b1;
        wait_ticks(2);

        // R10: break reported once, then silence while the line is low
        begin
            exp_t e;
            e.data = 8'h00;
            e.pe   = 1'b0;
            e.fe   = 1'b1;
            exp_q.push_back(e);
        end
        cnt0 = rx_count;
        rxd  = 1'b0;
        wait_ticks(16 * 10 + 96);
        chk("R10 break reported once", rx_count, cnt0 + 1);
        chk("R10 no character during break", {31'd0, rx_full}, 32'd0);
        rxd = 1'b1;
        wait_ticks(8);
        send_char(8'hE7, 1'b0, 1'b1);
        chk("R10 reception resumes", rx_count, cnt0 + 2);

        wait_ticks(8);
        chk("R3 all characters received", exp_q.size(), 32'd0);
        summary();
    end
endmodule